// File: doc/BRIEF.md
# Sample-count locked sampling clock

This block paces an ADC so that one period of a single-tone mains waveform is sampled exactly 128 times. A free-running interval timer issues a one-cycle conversion strobe, `conv_o`, each time it wraps. An external comparator supplies a synchronization edge at the same point of every input period. The level of that point is arbitrary, because only its repeatability matters. At every frame boundary the block compares the number of strobes seen since the previous boundary with 128. It then lengthens or shortens the timer interval by one clock, which locks the sampling rate to the input frequency.

The block also fills a 128-entry sample buffer through a plain write port. Each stored sample is the raw ADC code minus a tracked offset. Once per complete frame, that offset moves one code toward the DC level of the input. A decimated mode slows the sampling clock by eight, so that eight input periods fill one frame.

The ADC input is valid-only and is accepted every cycle. The buffer write port has no back-pressure, and a write is issued in the cycle after the data arrives. Downstream logic must accept one write per cycle.

Top module: `samp_lock`

## Requirements
- R1: While reset is held and in the first cycle after it, `period_o` equals DEF_PERIOD, and `conv_o`, `buf_we_o` and `frame_ready_o` are low.
- R2: `conv_o` is a single-cycle pulse. In normal mode consecutive pulses are exactly as many clocks apart as the interval the timer loaded when it last restarted. The first pulse after reset comes DEF_PERIOD clocks after release.
- R3: A new `period_o` value is picked up only when the timer restarts, so the interval that follows a pulse equals the `period_o` value held in the cycle in which that pulse was produced.
- R4: At a frame boundary, the period rises by one if more than 128 strobes fell in the frame just ended, falls by one if fewer fell, and stays the same if exactly 128 fell.
- R5: The period saturates and never goes below MIN_PERIOD or above MAX_PERIOD.
- R6: Strobes in a frame are numbered from 0. Only strobes numbered below 128 produce a buffer write. The next `adc_valid_i` after such a strobe writes `buf_addr_o` = strobe number, with `buf_data_o` = `adc_data_i` − offset as a signed value one bit wider than the ADC code. Strobes numbered 128 or higher produce no write.
- R7: `frame_ready_o` pulses for one cycle, in the cycle after a frame boundary, if and only if the frame just ended produced exactly 128 writes.
- R8: The offset resets to OFS_DEF. At a boundary that closes a full frame, it rises by one if the sum of that frame's stored samples is positive, falls by one if the sum is negative, and holds if the sum is zero. After a frame that is not full, it holds. The offset shows in `buf_data_o`.
- R9: With `decim_i` high, the strobe interval is eight times the loaded period, and only every eighth sync event is a frame boundary. Other sync events change neither `period_o` nor `frame_ready_o`.
- R10: `sync_i` passes through a two-flop synchronizer and its rising edge is detected. A rising edge sampled at a clock edge takes effect on `period_o` and `frame_ready_o` at the third edge after it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| decim_i | input | 1 | Decimated mode: sample eight times slower, eight sync events per frame |
| sync_i | input | 1 | Comparator sync level, rising edge marks the period point |
| adc_valid_i | input | 1 | ADC result valid, always accepted |
| adc_data_i | input | ADC_W | Raw unsigned ADC code |
| conv_o | output | 1 | Conversion-start strobe, one cycle |
| buf_we_o | output | 1 | Sample buffer write enable |
| buf_addr_o | output | 7 | Sample buffer write address |
| buf_data_o | output | ADC_W+1 | Offset-corrected signed sample |
| frame_ready_o | output | 1 | One-cycle pulse after a complete 128-sample frame |
| period_o | output | PER_W | Current timer interval in clocks |

## Verification
The hardest point to reach is the frame boundary itself. There the closing frame's last sample write, the first strobe of the next frame and the period update can all meet within two or three cycles. The stimulus therefore drives sync periods that are exact multiples of the interval, as well as periods well above and well below 128 intervals. This keeps the servo stepping, holding and pinned at each limit, and lets the strobe phase drift through the boundary. The bench splits strobes and writes between frames by the synchronizer latency. It predicts every period step, offset step and ready pulse from its own strobe and write counts.

// File: rtl/slk_pkg.sv
package slk_pkg;

  localparam int unsigned FRAME_LEN = 128;
  localparam int unsigned IDX_W     = $clog2(FRAME_LEN);
  localparam int unsigned CNT_W     = IDX_W + 2;

  typedef enum logic [1:0] {
    ADJ_HOLD = 2'd0,
    ADJ_UP   = 2'd1,
    ADJ_DOWN = 2'd2
  } adj_e;

  function automatic adj_e judge_count(input logic [CNT_W-1:0] n);
    if (n > CNT_W'(FRAME_LEN))      return ADJ_UP;
    else if (n < CNT_W'(FRAME_LEN)) return ADJ_DOWN;
    else                            return ADJ_HOLD;
  endfunction

endpackage

// File: rtl/slk_sync.sv
module slk_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned DECIM  = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic decim_i,
  input  logic sync_i,
  output logic bnd_o
);
  localparam int unsigned DW = (DECIM > 1) ? $clog2(DECIM) : 1;

  logic [STAGES:0] sh_q;
  logic [DW-1:0]   ev_cnt_q;
  logic            ev;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], sync_i};
  end

  assign ev    = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign bnd_o = ev & (!decim_i || (ev_cnt_q == DW'(DECIM - 1)));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ev_cnt_q <= '0;
    end else if (ev) begin
      if (!decim_i || ev_cnt_q == DW'(DECIM - 1)) ev_cnt_q <= '0;
      else                                        ev_cnt_q <= ev_cnt_q + 1'b1;
    end
  end

  // R10: two sync events are at least two cycles apart
  a_r10_event_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev |=> !ev);

endmodule

// File: rtl/slk_timer.sv
module slk_timer #(
  parameter int unsigned PER_W      = 16,
  parameter int unsigned DEF_PERIOD = 16276,
  parameter int unsigned DECIM      = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             decim_i,
  input  logic [PER_W-1:0] period_i,
  output logic             conv_o
);
  logic             tick;
  logic [PER_W-1:0] cnt_q;
  logic [PER_W-1:0] active_q;

  generate
    if (DECIM > 1) begin : g_pre
      localparam int unsigned PW = $clog2(DECIM);
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk_i) begin
        if (!rst_ni)                    pre_q <= '0;
        else if (pre_q == PW'(DECIM-1)) pre_q <= '0;
        else                            pre_q <= pre_q + 1'b1;
      end
      assign tick = !decim_i || (pre_q == PW'(DECIM - 1));
    end else begin : g_nopre
      assign tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= PER_W'(DEF_PERIOD);
      conv_o   <= 1'b0;
    end else if (tick) begin
      if (cnt_q == active_q - PER_W'(1)) begin
        cnt_q    <= '0;
        active_q <= period_i;
        conv_o   <= 1'b1;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
        conv_o <= 1'b0;
      end
    end else begin
      conv_o <= 1'b0;
    end
  end

  // R2: strobe is one cycle wide
  a_r2_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_o |=> !conv_o);

  // R3: loaded interval only changes when the timer wraps
  a_r3_load_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(active_q) |-> conv_o);

endmodule

// File: rtl/slk_servo.sv
module slk_servo
  import slk_pkg::*;
#(
  parameter int unsigned PER_W      = 16,
  parameter int unsigned DEF_PERIOD = 16276,
  parameter int unsigned MIN_PERIOD = 8000,
  parameter int unsigned MAX_PERIOD = 30000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bnd_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [PER_W-1:0] period_o
);
  logic [PER_W-1:0] period_q;
  adj_e             adj;

  assign adj      = judge_count(count_i);
  assign period_o = period_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      period_q <= PER_W'(DEF_PERIOD);
    end else if (bnd_i) begin
      unique case (adj)
        ADJ_UP:   if (period_q < PER_W'(MAX_PERIOD)) period_q <= period_q + 1'b1;
        ADJ_DOWN: if (period_q > PER_W'(MIN_PERIOD)) period_q <= period_q - 1'b1;
        default:  period_q <= period_q;
      endcase
    end
  end

  // R5: period stays inside its limits
  a_r5_period_bounds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_q >= PER_W'(MIN_PERIOD)) && (period_q <= PER_W'(MAX_PERIOD)));

  // R4: period moves by exactly one step
  a_r4_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(period_q) |->
      (period_q == $past(period_q) + PER_W'(1)) || (period_q == $past(period_q) - PER_W'(1)));

  // R4: period moves only at a frame boundary
  a_r4_moves_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(period_q) |-> $past(bnd_i));

endmodule

// File: rtl/slk_frame.sv
module slk_frame
  import slk_pkg::*;
#(
  parameter int unsigned ADC_W   = 10,
  parameter int unsigned OFS_DEF = 512
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    conv_i,
  input  logic                    bnd_i,
  input  logic                    adc_valid_i,
  input  logic [ADC_W-1:0]        adc_data_i,
  output logic                    buf_we_o,
  output logic [IDX_W-1:0]        buf_addr_o,
  output logic signed [ADC_W:0]   buf_data_o,
  output logic                    frame_ready_o,
  output logic [CNT_W-1:0]        count_o
);
  localparam int unsigned SMP_W = ADC_W + 1;
  localparam int unsigned SUM_W = SMP_W + IDX_W + 1;

  logic [CNT_W-1:0]        idx_q;
  logic                    pend_q;
  logic [IDX_W-1:0]        pend_addr_q;
  logic [IDX_W:0]          wr_q;
  logic signed [SUM_W-1:0] sum_q;
  logic [ADC_W-1:0]        ofs_q;

  logic signed [SMP_W-1:0] smp;
  logic signed [SUM_W-1:0] smp_ext;
  logic signed [SUM_W-1:0] dc_now;
  logic [IDX_W:0]          wr_next;
  logic                    we_now;
  logic                    full;

  assign smp     = $signed({1'b0, adc_data_i}) - $signed({1'b0, ofs_q});
  assign smp_ext = $signed({{(SUM_W-SMP_W){smp[SMP_W-1]}}, smp});
  assign we_now  = adc_valid_i & pend_q;
  assign wr_next = wr_q + (IDX_W+1)'(we_now);
  assign dc_now  = we_now ? (sum_q + smp_ext) : sum_q;
  assign full    = (wr_next == (IDX_W+1)'(FRAME_LEN));
  assign count_o = idx_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      buf_we_o   <= 1'b0;
      buf_addr_o <= '0;
      buf_data_o <= '0;
    end else begin
      buf_we_o <= we_now;
      if (we_now) begin
        buf_addr_o <= pend_addr_q;
        buf_data_o <= smp;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      idx_q         <= '0;
      pend_q        <= 1'b0;
      pend_addr_q   <= '0;
      wr_q          <= '0;
      sum_q         <= '0;
      ofs_q         <= ADC_W'(OFS_DEF);
      frame_ready_o <= 1'b0;
    end else if (bnd_i) begin
      frame_ready_o <= full;
      if (full) begin
        if (dc_now > 0 && ofs_q != '1)      ofs_q <= ofs_q + 1'b1;
        else if (dc_now < 0 && ofs_q != '0) ofs_q <= ofs_q - 1'b1;
      end
      sum_q       <= '0;
      wr_q        <= '0;
      pend_addr_q <= '0;
      pend_q      <= conv_i;
      idx_q       <= conv_i ? CNT_W'(1) : '0;
    end else begin
      frame_ready_o <= 1'b0;
      sum_q         <= dc_now;
      wr_q          <= wr_next;
      if (we_now) pend_q <= 1'b0;
      if (conv_i) begin
        if (idx_q != '1) idx_q <= idx_q + 1'b1;
        if (idx_q < CNT_W'(FRAME_LEN)) begin
          pend_q      <= 1'b1;
          pend_addr_q <= idx_q[IDX_W-1:0];
        end
      end
    end
  end

  // R7: ready is a single-cycle pulse
  a_r7_ready_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_ready_o |=> !frame_ready_o);

  // R8: offset only moves when a full frame closes
  a_r8_offset_on_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ofs_q) |-> frame_ready_o);

  // R6: no more than one frame's worth of writes
  a_r6_write_budget: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_q <= (IDX_W+1)'(FRAME_LEN));

endmodule

// File: rtl/samp_lock.sv
module samp_lock
  import slk_pkg::*;
#(
  parameter int unsigned ADC_W      = 10,
  parameter int unsigned PER_W      = 16,
  parameter int unsigned DEF_PERIOD = 16276,
  parameter int unsigned MIN_PERIOD = 8000,
  parameter int unsigned MAX_PERIOD = 30000,
  parameter int unsigned OFS_DEF    = 512,
  parameter int unsigned DECIM      = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  decim_i,
  input  logic                  sync_i,
  input  logic                  adc_valid_i,
  input  logic [ADC_W-1:0]      adc_data_i,
  output logic                  conv_o,
  output logic                  buf_we_o,
  output logic [6:0]            buf_addr_o,
  output logic signed [ADC_W:0] buf_data_o,
  output logic                  frame_ready_o,
  output logic [PER_W-1:0]      period_o
);
  logic             bnd;
  logic [CNT_W-1:0] count;

  slk_sync #(.STAGES(2), .DECIM(DECIM)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .decim_i(decim_i),
    .sync_i(sync_i), .bnd_o(bnd)
  );

  slk_timer #(.PER_W(PER_W), .DEF_PERIOD(DEF_PERIOD), .DECIM(DECIM)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .decim_i(decim_i),
    .period_i(period_o), .conv_o(conv_o)
  );

  slk_servo #(.PER_W(PER_W), .DEF_PERIOD(DEF_PERIOD),
              .MIN_PERIOD(MIN_PERIOD), .MAX_PERIOD(MAX_PERIOD)) u_servo (
    .clk_i(clk_i), .rst_ni(rst_ni), .bnd_i(bnd),
    .count_i(count), .period_o(period_o)
  );

  slk_frame #(.ADC_W(ADC_W), .OFS_DEF(OFS_DEF)) u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .conv_i(conv_o), .bnd_i(bnd),
    .adc_valid_i(adc_valid_i), .adc_data_i(adc_data_i),
    .buf_we_o(buf_we_o), .buf_addr_o(buf_addr_o), .buf_data_o(buf_data_o),
    .frame_ready_o(frame_ready_o), .count_o(count)
  );

endmodule

// File: tb/samp_lock_tb_top.sv
module samp_lock_tb_top;
  localparam int ADC_W = 10;
  localparam int PER_W = 16;
  localparam int DEF_P = 20;
  localparam int MIN_P = 16;
  localparam int MAX_P = 24;
  localparam int OFS0  = 512;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                  rst_ni = 1'b0;
  logic                  decim_i = 1'b0;
  logic                  sync_i = 1'b0;
  logic                  adc_valid_i = 1'b0;
  logic [ADC_W-1:0]      adc_data_i = '0;
  logic                  conv_o, buf_we_o, frame_ready_o;
  logic [6:0]            buf_addr_o;
  logic signed [ADC_W:0] buf_data_o;
  logic [PER_W-1:0]      period_o;

  samp_lock #(.ADC_W(ADC_W), .PER_W(PER_W), .DEF_PERIOD(DEF_P),
              .MIN_PERIOD(MIN_P), .MAX_PERIOD(MAX_P), .OFS_DEF(OFS0), .DECIM(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .decim_i(decim_i), .sync_i(sync_i),
    .adc_valid_i(adc_valid_i), .adc_data_i(adc_data_i), .conv_o(conv_o),
    .buf_we_o(buf_we_o), .buf_addr_o(buf_addr_o), .buf_data_o(buf_data_o),
    .frame_ready_o(frame_ready_o), .period_o(period_o)
  );

  int total = 0, fails = 0;
  int q_raw[$];
  int q_addr[$];
  int cyc = 0, t_phase = 0, next_sync = 0, sync_per = 2560, pat = 0;
  int age = 1000, ev_cnt = 0, cnt_strobe = 0, exp_per = DEF_P, next_per = DEF_P;
  int exp_off = OFS0, exp_wr = 0, exp_sum = 0, per_prev = DEF_P;
  int last_t = 0, exp_int = DEF_P, prev_int = DEF_P;
  bit this_bnd = 0, sched_v = 0;
  int sched_raw = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  function automatic int raw_of(input int a);
    case (pat)
      0:       raw_of = (a % 2 == 1) ? OFS0 + 5 : OFS0 - 5;
      1:       raw_of = 600 + (a % 4);
      default: raw_of = 400 + (a % 3);
    endcase
  endfunction

  task automatic do_reset(input bit dm);
    rst_ni = 1'b0; sync_i = 1'b0; adc_valid_i = 1'b0; decim_i = dm;
    q_raw.delete(); q_addr.delete();
    for (int i = 0; i < 4; i++) begin @(negedge clk); cyc++; end
    chk(period_o == PER_W'(DEF_P), "R1 period", int'(period_o), DEF_P);
    chk(!conv_o && !buf_we_o && !frame_ready_o, "R1 outputs low",
        int'({conv_o, buf_we_o, frame_ready_o}), 0);
    rst_ni = 1'b1;
    last_t = cyc; exp_int = DEF_P * (dm ? 8 : 1); prev_int = exp_int;
    age = 1000; ev_cnt = 0; cnt_strobe = 0; exp_per = DEF_P; next_per = DEF_P;
    exp_off = OFS0; exp_wr = 0; exp_sum = 0; per_prev = DEF_P; sched_v = 0; this_bnd = 0;
  endtask

  task automatic step();
    @(negedge clk); cyc++; t_phase++;
    if (age < 1000) age++;
    // monitor: scoreboard of buffer writes
    if (buf_we_o) begin
      if (q_raw.size() == 0) begin
        chk(0, "R6 unexpected write", int'(buf_addr_o), -1);
      end else begin
        int r, a, d;
        r = q_raw.pop_front(); a = q_addr.pop_front();
        d = r - exp_off;
        chk(int'(buf_addr_o) == a, "R6 address", int'(buf_addr_o), a);
        chk(int'(buf_data_o) == d, "R6 data", int'(buf_data_o), d);
        exp_wr++; exp_sum += d;
      end
    end
    // boundary, second half: results visible
    if (age == 3) begin
      if (this_bnd) begin
        bit full;
        full = (exp_wr == 128);
        chk(frame_ready_o == full, "R7 frame ready", int'(frame_ready_o), int'(full));
        chk(int'(period_o) == next_per, (next_per == exp_per) ? "R4 hold/limit" : "R4 step",
            int'(period_o), next_per);
        if (full) begin
          if (exp_sum > 0 && exp_off < 1023) exp_off++;
          else if (exp_sum < 0 && exp_off > 0) exp_off--;
        end
        exp_wr = 0; exp_sum = 0; exp_per = next_per;
      end else begin
        chk(frame_ready_o == 1'b0, "R9 no ready mid-frame", int'(frame_ready_o), 0);
        chk(int'(period_o) == exp_per, "R9 period held mid-frame", int'(period_o), exp_per);
      end
    end
    // boundary, first half: split strobe count
    if (age == 2) begin
      this_bnd = !decim_i || (ev_cnt == 7);
      ev_cnt = decim_i ? (ev_cnt + 1) % 8 : 0;
      if (this_bnd) begin
        chk(int'(period_o) == exp_per, "R10 not early", int'(period_o), exp_per);
        if (cnt_strobe > 128)      next_per = (exp_per < MAX_P) ? exp_per + 1 : MAX_P;
        else if (cnt_strobe < 128) next_per = (exp_per > MIN_P) ? exp_per - 1 : MIN_P;
        else                       next_per = exp_per;
        if (next_per == exp_per && cnt_strobe != 128)
          chk(exp_per == MIN_P || exp_per == MAX_P, "R5 limit", exp_per, MIN_P);
        cnt_strobe = 0;
      end
    end
    // ADC model drive
    adc_valid_i = sched_v;
    adc_data_i  = ADC_W'(sched_raw);
    sched_v = 0;
    // strobe observation
    if (conv_o) begin
      chk(cyc - last_t == exp_int, (exp_int == prev_int) ? "R2 interval" : "R3 new interval",
          cyc - last_t, exp_int);
      prev_int = exp_int;
      exp_int = per_prev * (decim_i ? 8 : 1);
      last_t = cyc;
      if (cnt_strobe < 128) begin
        sched_v = 1; sched_raw = raw_of(cnt_strobe);
        q_raw.push_back(sched_raw); q_addr.push_back(cnt_strobe);
      end
      cnt_strobe++;
    end
    // sync driver
    if (t_phase == next_sync) begin
      sync_i = 1'b1; age = 0; next_sync += sync_per;
    end else if (age == 10) begin
      sync_i = 1'b0;
    end
    per_prev = int'(period_o);
  endtask

  task automatic run_phase(input bit dm, input int p, input int s, input int n);
    do_reset(dm);
    pat = p; sync_per = s; t_phase = 0; next_sync = s / 2;
    repeat (n * s + 20) step();
  endtask

  initial begin
    // R4 hold and steps, R8 zero-sum hold
    run_phase(1'b0, 0, 2560, 6);
    // R5 upper limit, R6 surplus strobes, R8 offset up
    run_phase(1'b0, 1, 4000, 8);
    // R5 lower limit, R7 short frames give no ready
    run_phase(1'b0, 2, 1500, 8);
    // R8 offset down on full frames
    run_phase(1'b0, 2, 2560, 5);
    // R9 decimated mode
    run_phase(1'b1, 0, 2560, 17);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule